// File: doc/BRIEF.md
# Cascadable Eight-Input Priority Interrupt Controller

This block gathers eight interrupt request lines, ranks them by a fixed priority, and raises a single interrupt output toward a processor. Software programs it through a byte-wide write port with two addresses, an even one and an odd one. A short, ordered run of configuration bytes sets how it operates. After that, bytes written to the odd address load the interrupt mask. Bytes written to the even address either restart configuration or retire the highest-priority interrupt that is in service. When the processor acknowledges, the controller returns an eight-bit vector: the programmed base plus the number of the winning input.

Two copies can be chained. The first acts as the master. The second acts as a slave whose interrupt output drives master input 2, which gives fifteen usable lines. When the master acknowledges an input that it was told carries a slave, it does not drive a vector. Instead it broadcasts that input's number on a cascade bus. The slave programmed with that number then answers with its own vector. The same number of register stages sits between the acknowledge and the vector in both cases, so the processor sees the same timing either way.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: After reset, and until a configuration sequence completes, `int_out` and `vec_en` stay low. Requests made during that time are discarded when configuration starts.
- R2: A write to the even address with bit 4 set starts configuration. In that byte, bit 0 means a mode byte will follow, bit 1 selects single (non-chained) operation, and bit 3 selects level sensing. The next odd write is the vector base. The cascade byte comes next only when bit 1 was 0, and the mode byte comes next only when bit 0 was 1. Every later odd write is the mask, where bit n set masks input n.
- R3: One cycle after an acknowledge that wins input n, `vec_en` is high for exactly that cycle and `vec_out` equals the base plus n.
- R4: Priority is fixed, and input 0 ranks highest. When several requests are pending, the lowest-numbered unmasked one is served first.
- R5: A masked input never raises `int_out`. An edge that arrives while the input is masked is still remembered, and it is presented once the mask bit is cleared.
- R6: Without automatic end of interrupt, an in-service input blocks requests of equal and lower priority, while a higher-priority request still raises `int_out`. A write of 0x20 to the even address (bit 4 = 0, bits 7:5 = 001) retires only the highest-priority in-service input.
- R7: When mode byte bit 0 is set (automatic end of interrupt), the in-service mark is cleared right after the vector cycle, so a lower-priority request is presented with no end-of-interrupt write.
- R8: In the master, the cascade byte is a bit mask of inputs that carry a slave. In a slave, bits 2:0 of the cascade byte are its identity. When the master acknowledges a slave input, it drives `cas_act_out` and puts the input number on `cas_id_out`, and it does not assert `vec_en`. The slave whose identity matches returns its own base plus its winning input.
- R9: When mode byte bit 4 is set (special nesting), a master whose slave input is in service still presents a new request on that same input. A slave that receives a new, higher-priority request can therefore interrupt again.
- R10: In edge mode, a line held high yields one request, and a new request needs a low-to-high transition. In level mode, the request follows the line: it comes back after an end of interrupt if the line is still high, and it goes away when the line drops.
- R11: An acknowledge with nothing presented returns the base plus 7 and marks nothing in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Chip select for the write port |
| a0 | input | 1 | Address bit: 0 = even, 1 = odd |
| wr | input | 1 | Write strobe, one cycle per byte |
| wdata | input | 8 | Write data |
| master_sel | input | 1 | 1 = act as master (or single), 0 = act as slave |
| irq_in | input | 8 | Interrupt request lines |
| int_out | output | 1 | Interrupt request to the processor or the upstream master |
| inta | input | 1 | Acknowledge pulse, one cycle |
| cas_id_out | output | 3 | Acknowledged input number broadcast to slaves |
| cas_act_out | output | 1 | High while the master defers the vector to a slave |
| cas_id_in | input | 3 | Cascade number from the master (slave role) |
| cas_act_in | input | 1 | Cascade select from the master (slave role) |
| vec_out | output | 8 | Vector byte |
| vec_en | output | 1 | Vector valid, one cycle after an acknowledge |

## Verification
The hardest situation to reach from the ports is special nesting across the chain. The master must already have its slave input in service, and the slave must then raise a new request that outranks its own in-service input. That request must create a fresh edge on the master's input 2. The bench gets there in a fixed order: it programs the master without automatic end of interrupt, pulses a low-priority slave line, and acknowledges it. The slave's output then falls as its request is cleared. The bench then pulses a higher-priority slave line and watches the master interrupt again and return the slave's vector. A reference model of both controllers, updated every clock, checks all traffic in between.

// File: rtl/irqc_pkg.sv
// Package irqc_pkg
// Shared types and bit positions for the cascadable interrupt controller.
// Assumes a byte-wide write port; all command fields fit in one byte.
package irqc_pkg;
    localparam int BYTE_W = 8;

    // Bit positions inside the configuration bytes
    localparam int CFG1_TAG_B    = 4;  // even-address byte: 1 = start config
    localparam int CFG1_MODE_B   = 0;  // mode byte follows
    localparam int CFG1_SINGLE_B = 1;  // single operation, no cascade byte
    localparam int CFG1_LEVEL_B  = 3;  // level sensing
    localparam int MODE_AUTO_B   = 0;  // automatic end of interrupt
    localparam int MODE_NEST_B   = 4;  // special nesting on slave inputs

    typedef enum logic [2:0] {
        ST_UNCONF,
        ST_BASE,
        ST_CASC,
        ST_MODE,
        ST_READY
    } cfg_state_e;

    typedef struct packed {
        logic              need_mode;
        logic              single;
        logic              level;
        logic              auto_eoi;
        logic              nest;
        logic [BYTE_W-1:0] base;
        logic [BYTE_W-1:0] casc;
    } irqc_cfg_t;
endpackage

// File: rtl/irqc_cfg_seq.sv
// Module irqc_cfg_seq
// Walks the ordered configuration byte sequence, holds the configuration
// and the mask, and decodes start-of-config and end-of-interrupt strokes.
// Assumes wr_en is a single-cycle strobe already qualified by chip select.
module irqc_cfg_seq
    import irqc_pkg::*;
#(
    parameter int N_IN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              a0,
    input  logic [BYTE_W-1:0] wdata,
    output irqc_cfg_t         cfg,
    output logic [N_IN-1:0]   imr,
    output logic              ready,
    output logic              start_pulse,
    output logic              eoi_pulse
);
    cfg_state_e st_q;
    irqc_cfg_t  cfg_q;
    logic [N_IN-1:0] imr_q;

    // Even-address stroke decode: restart or non-specific end of interrupt
    always_comb begin
        start_pulse = wr_en & ~a0 & wdata[CFG1_TAG_B];
        eoi_pulse   = wr_en & ~a0 & ~wdata[CFG1_TAG_B] &
                      (wdata[7:5] == 3'b001) & (st_q == ST_READY);
    end

    // Configuration state machine with its held fields and the mask
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_UNCONF;
            cfg_q <= '0;
            imr_q <= '0;
        end else if (start_pulse) begin
            st_q            <= ST_BASE;
            cfg_q.need_mode <= wdata[CFG1_MODE_B];
            cfg_q.single    <= wdata[CFG1_SINGLE_B];
            cfg_q.level     <= wdata[CFG1_LEVEL_B];
            cfg_q.auto_eoi  <= 1'b0;
            cfg_q.nest      <= 1'b0;
            imr_q           <= '0;
        end else if (wr_en && a0) begin
            case (st_q)
                ST_BASE: begin
                    cfg_q.base <= wdata;
                    st_q <= cfg_q.single ? (cfg_q.need_mode ? ST_MODE : ST_READY)
                                         : ST_CASC;
                end
                ST_CASC: begin
                    cfg_q.casc <= wdata;
                    st_q <= cfg_q.need_mode ? ST_MODE : ST_READY;
                end
                ST_MODE: begin
                    cfg_q.auto_eoi <= wdata[MODE_AUTO_B];
                    cfg_q.nest     <= wdata[MODE_NEST_B];
                    st_q           <= ST_READY;
                end
                ST_READY: imr_q <= wdata[N_IN-1:0];
                default: ;
            endcase
        end
    end

    assign cfg   = cfg_q;
    assign imr   = imr_q;
    assign ready = (st_q == ST_READY);
endmodule

// File: rtl/irqc_req_latch.sv
// Module irqc_req_latch
// Request register: captures rising edges (edge mode) or follows the lines
// (level mode); acknowledged bits are cleared; a restart flushes it.
// Assumes request lines are already synchronous to clk.
module irqc_req_latch #(
    parameter int N_IN = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic            level,
    input  logic [N_IN-1:0] irq,
    input  logic [N_IN-1:0] ack_clr,
    output logic [N_IN-1:0] irr
);
    logic [N_IN-1:0] prev_q;
    logic [N_IN-1:0] irr_q;

    // Edge history and request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            irr_q  <= '0;
        end else begin
            prev_q <= irq;
            if (flush)      irr_q <= '0;
            else if (level) irr_q <= irq & ~ack_clr;
            else            irr_q <= (irr_q | (irq & ~prev_q)) & ~ack_clr;
        end
    end

    assign irr = irr_q;
endmodule

// File: rtl/irqc_resolver.sv
// Module irqc_resolver
// Fixed-priority resolver: input 0 ranks highest. Presents the best
// unmasked request when it outranks all in-service inputs, or equals an
// in-service input that is allowed to nest on itself.
module irqc_resolver #(
    parameter int N_IN = 8,
    localparam int IDX_W = $clog2(N_IN)
) (
    input  logic [N_IN-1:0]  irr,
    input  logic [N_IN-1:0]  imr,
    input  logic [N_IN-1:0]  isr,
    input  logic [N_IN-1:0]  allow_eq,
    output logic [IDX_W-1:0] req_idx,
    output logic             present
);
    logic [N_IN-1:0]  pend;
    logic [IDX_W-1:0] svc_idx;
    logic             pend_any, svc_any;

    // Priority encode the pending and in-service sets, then compare
    always_comb begin
        pend     = irr & ~imr;
        req_idx  = '0;
        svc_idx  = '0;
        pend_any = 1'b0;
        svc_any  = 1'b0;
        for (int i = N_IN - 1; i >= 0; i--) begin
            if (pend[i]) begin
                req_idx  = i[IDX_W-1:0];
                pend_any = 1'b1;
            end
            if (isr[i]) begin
                svc_idx = i[IDX_W-1:0];
                svc_any = 1'b1;
            end
        end
        present = pend_any & (~svc_any | (req_idx < svc_idx) |
                              ((req_idx == svc_idx) & allow_eq[req_idx]));
    end
endmodule

// File: rtl/cascade_irq_ctrl.sv
// Module cascade_irq_ctrl
// Top of the interrupt controller: configuration, request capture,
// priority, in-service tracking, acknowledge and cascade vector hand-off.
// Assumes inta is a one-cycle pulse and, in a chain, both controllers see it.
module cascade_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int N_IN = 8,
    localparam int IDX_W = $clog2(N_IN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              a0,
    input  logic              wr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              master_sel,
    input  logic [N_IN-1:0]   irq_in,
    output logic              int_out,
    input  logic              inta,
    output logic [IDX_W-1:0]  cas_id_out,
    output logic              cas_act_out,
    input  logic [IDX_W-1:0]  cas_id_in,
    input  logic              cas_act_in,
    output logic [BYTE_W-1:0] vec_out,
    output logic              vec_en
);
    localparam logic [N_IN-1:0] ONE = {{(N_IN-1){1'b0}}, 1'b1};

    irqc_cfg_t         cfg;
    logic [N_IN-1:0]   imr, irr, isr_q, allow_eq, set_v, clr_v, ack_clr;
    logic              ready, start_pulse, eoi_pulse, present;
    logic [IDX_W-1:0]  req_idx, vec_idx, ack_idx_q;
    logic              slave_role, cas_en, ack, m_take, cas_hit, s_sel, s_take;
    logic              take, drive, ack_set_q;
    logic [BYTE_W-1:0] vec_q;
    logic              vec_en_q;

    irqc_cfg_seq #(.N_IN(N_IN)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr & cs), .a0(a0), .wdata(wdata),
        .cfg(cfg), .imr(imr), .ready(ready),
        .start_pulse(start_pulse), .eoi_pulse(eoi_pulse)
    );

    irqc_req_latch #(.N_IN(N_IN)) u_req (
        .clk(clk), .rst_n(rst_n), .flush(start_pulse), .level(cfg.level),
        .irq(irq_in), .ack_clr(ack_clr), .irr(irr)
    );

    irqc_resolver #(.N_IN(N_IN)) u_res (
        .irr(irr), .imr(imr), .isr(isr_q), .allow_eq(allow_eq),
        .req_idx(req_idx), .present(present)
    );

    // Role, acknowledge and cascade hand-off decisions
    always_comb begin
        slave_role = ~master_sel & ~cfg.single;
        cas_en     = master_sel & ~cfg.single;
        allow_eq   = cfg.casc[N_IN-1:0] & {N_IN{cfg.nest & cas_en}};
        ack        = inta & ready;
        m_take     = ack & ~slave_role & present;
        cas_hit    = m_take & cas_en & cfg.casc[req_idx];
        s_sel      = ack & slave_role & cas_act_in & (cas_id_in == cfg.casc[IDX_W-1:0]);
        s_take     = s_sel & present;
        take       = m_take | s_take;
        drive      = (ack & ~slave_role & ~cas_hit) | s_sel;
        vec_idx    = take ? req_idx : IDX_W'(N_IN - 1);
        ack_clr    = take ? (ONE << req_idx) : '0;
        set_v      = ack_clr;
        clr_v      = '0;
        if (eoi_pulse)                 clr_v = clr_v | (isr_q & (~isr_q + ONE));
        if (cfg.auto_eoi && ack_set_q) clr_v = clr_v | (ONE << ack_idx_q);
    end

    // In-service register and registered vector output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr_q     <= '0;
            vec_q     <= '0;
            vec_en_q  <= 1'b0;
            ack_set_q <= 1'b0;
            ack_idx_q <= '0;
        end else begin
            isr_q     <= start_pulse ? '0 : ((isr_q | set_v) & ~clr_v);
            vec_en_q  <= drive;
            if (drive) vec_q <= cfg.base + BYTE_W'(vec_idx);
            ack_set_q <= take;
            ack_idx_q <= req_idx;
        end
    end

    assign int_out     = ready & present;
    assign cas_id_out  = req_idx;
    assign cas_act_out = cas_hit;
    assign vec_out     = vec_q;
    assign vec_en      = vec_en_q;
endmodule

// File: rtl/irqc_checker.sv
// Module irqc_checker
// Temporal checks on the controller, bound to every instance of the top.
module irqc_checker #(
    parameter int N_IN = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ready,
    input logic            int_out,
    input logic            inta,
    input logic            vec_en,
    input logic            cas_act_out,
    input logic            auto_eoi,
    input logic            eoi_pulse,
    input logic            take,
    input logic [N_IN-1:0] irr,
    input logic [N_IN-1:0] imr,
    input logic [N_IN-1:0] isr
);
    a_r1_quiet_unready: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !int_out);

    a_r5_int_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> ((irr & ~imr) != '0));

    a_r3_vec_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        vec_en |-> $past(inta));

    a_r8_master_defers: assert property (@(posedge clk) disable iff (!rst_n)
        cas_act_out |=> !vec_en);

    a_r7_auto_single: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_eoi && ready) |-> ($countones(isr) <= 1));

    a_r6_eoi_drops_one: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_pulse && !auto_eoi && !take && (isr != '0)) |=>
        ($countones(isr) == $past($countones(isr)) - 1));
endmodule

bind cascade_irq_ctrl irqc_checker #(.N_IN(N_IN)) u_chk (
    .clk(clk), .rst_n(rst_n), .ready(ready), .int_out(int_out), .inta(inta),
    .vec_en(vec_en), .cas_act_out(cas_act_out), .auto_eoi(cfg.auto_eoi),
    .eoi_pulse(eoi_pulse), .take(take), .irr(irr), .imr(imr), .isr(isr_q)
);

// File: tb/cascade_irq_ctrl_bench.sv
`timescale 1ns/1ps
// Bench: a master and a slave chained on input 2, a behavioural model of
// both compared every clock, plus directed checks per requirement.
module cascade_irq_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr = 8'h00, wdata = 8'h00;
    logic       wr = 1'b0, inta = 1'b0;
    logic [7:0] m_irq = 8'h00, s_irq = 8'h00;

    logic       m_int, s_int, m_ven, s_ven, m_cas_act, s_cas_act;
    logic [2:0] m_cas_id, s_cas_id;
    logic [7:0] m_vec, s_vec;
    logic       vec_valid;
    logic [7:0] vec_bus;

    int checks = 0, failures = 0;
    bit done = 0;
    logic       cas_seen;
    logic [2:0] cas_id_seen;

    always #5 clk = ~clk;

    cascade_irq_ctrl u_cascade_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .cs(addr[7:1] == 7'h10), .a0(addr[0]),
        .wr(wr), .wdata(wdata), .master_sel(1'b1),
        .irq_in({m_irq[7:3], s_int, m_irq[1:0]}), .int_out(m_int), .inta(inta),
        .cas_id_out(m_cas_id), .cas_act_out(m_cas_act),
        .cas_id_in(3'd0), .cas_act_in(1'b0), .vec_out(m_vec), .vec_en(m_ven)
    );

    cascade_irq_ctrl u_slave (
        .clk(clk), .rst_n(rst_n), .cs(addr[7:1] == 7'h50), .a0(addr[0]),
        .wr(wr), .wdata(wdata), .master_sel(1'b0),
        .irq_in(s_irq), .int_out(s_int), .inta(inta),
        .cas_id_out(s_cas_id), .cas_act_out(s_cas_act),
        .cas_id_in(m_cas_id), .cas_act_in(m_cas_act), .vec_out(s_vec), .vec_en(s_ven)
    );

    assign vec_valid = m_ven | s_ven;
    assign vec_bus   = m_ven ? m_vec : s_vec;

    // ---------------- behavioural reference model (index 0 master, 1 slave)
    int       md_st [2];
    bit       md_mode [2], md_sngl [2], md_lvl [2], md_auto [2], md_nest [2], md_last [2];
    bit [7:0] md_base [2], md_casc [2], md_imr [2], md_irr [2], md_isr [2], md_prev [2];
    int       md_lastidx [2];
    bit       md_ven;
    bit [7:0] md_vec;

    function automatic int first1(bit [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return i;
        return 8;
    endfunction

    function automatic bit mpres(int c);
        int p, s;
        p = first1(md_irr[c] & ~md_imr[c]);
        s = first1(md_isr[c]);
        if (md_st[c] != 4 || p == 8) return 0;
        if (p < s) return 1;
        if (p == s && c == 0 && md_nest[c] && !md_sngl[c] && md_casc[c][p]) return 1;
        return 0;
    endfunction

    task automatic chip_step(int c, bit [7:0] irqv, bit take, int idx);
        bit cs_c, wr_c, start, eoi;
        bit [7:0] clr, set;
        int f;
        cs_c  = (c == 0) ? (addr[7:1] == 7'h10) : (addr[7:1] == 7'h50);
        wr_c  = wr && cs_c;
        start = wr_c && !addr[0] && wdata[4];
        eoi   = wr_c && !addr[0] && !wdata[4] && wdata[7:5] == 3'b001 && md_st[c] == 4;
        clr = 0; set = 0;
        f = first1(md_isr[c]);
        if (eoi && f < 8) clr[f] = 1'b1;
        if (md_auto[c] && md_last[c]) clr[md_lastidx[c]] = 1'b1;
        if (take) set[idx] = 1'b1;
        md_isr[c] = start ? 8'h00 : ((md_isr[c] | set) & ~clr);
        if (start)          md_irr[c] = 8'h00;
        else if (md_lvl[c]) md_irr[c] = irqv & ~set;
        else                md_irr[c] = (md_irr[c] | (irqv & ~md_prev[c])) & ~set;
        md_prev[c] = irqv;
        md_last[c] = take;
        md_lastidx[c] = (idx > 7) ? 0 : idx;
        if (start) begin
            md_st[c] = 1; md_mode[c] = wdata[0]; md_sngl[c] = wdata[1];
            md_lvl[c] = wdata[3]; md_auto[c] = 0; md_nest[c] = 0; md_imr[c] = 0;
        end else if (wr_c && addr[0]) begin
            case (md_st[c])
                1: begin md_base[c] = wdata; md_st[c] = md_sngl[c] ? (md_mode[c] ? 3 : 4) : 2; end
                2: begin md_casc[c] = wdata; md_st[c] = md_mode[c] ? 3 : 4; end
                3: begin md_auto[c] = wdata[0]; md_nest[c] = wdata[4]; md_st[c] = 4; end
                4: md_imr[c] = wdata;
                default: ;
            endcase
        end
    endtask

    task automatic model_step();
        bit pr0, pr1, ack0, mtake, mcas, ssel, stake;
        int p0, p1;
        bit [7:0] irq0;
        pr0 = mpres(0); pr1 = mpres(1);
        p0 = first1(md_irr[0] & ~md_imr[0]);
        p1 = first1(md_irr[1] & ~md_imr[1]);
        irq0 = m_irq; irq0[2] = pr1;
        ack0  = inta && md_st[0] == 4;
        mtake = ack0 && pr0;
        mcas  = mtake && !md_sngl[0] && md_casc[0][p0];
        ssel  = inta && md_st[1] == 4 && !md_sngl[1] && mcas && (p0 == int'(md_casc[1][2:0]));
        stake = ssel && pr1;
        if (ack0 && !mcas) begin
            md_ven = 1; md_vec = md_base[0] + (mtake ? 8'(p0) : 8'd7);
        end else if (ssel) begin
            md_ven = 1; md_vec = md_base[1] + (stake ? 8'(p1) : 8'd7);
        end else md_ven = 0;
        chip_step(0, irq0, mtake, p0);
        chip_step(1, s_irq, stake, p1);
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                md_st[c] = 0; md_mode[c] = 0; md_sngl[c] = 0; md_lvl[c] = 0;
                md_auto[c] = 0; md_nest[c] = 0; md_last[c] = 0; md_base[c] = 0;
                md_casc[c] = 0; md_imr[c] = 0; md_irr[c] = 0; md_isr[c] = 0;
                md_prev[c] = 0; md_lastidx[c] = 0;
            end
            md_ven = 0; md_vec = 0;
        end else model_step();
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-clock comparison against the model (R3 vectors, R4 priority)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R4 model master int", int'(m_int), int'(mpres(0)));
            chk("R8 model slave int", int'(s_int), int'(mpres(1)));
            chk("R3 model vec valid", int'(vec_valid), int'(md_ven));
            if (md_ven) chk("R3 model vector", int'(vec_bus), int'(md_vec));
        end
    end

    // ---------------- stimulus helpers
    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_bus(logic [7:0] a, logic [7:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic pulse_m(int i);
        m_irq[i] = 1'b1; cyc(1); m_irq[i] = 1'b0; cyc(2);
    endtask

    task automatic pulse_s(int i);
        s_irq[i] = 1'b1; cyc(1); s_irq[i] = 1'b0; cyc(3);
    endtask

    task automatic ack_expect(string tag, logic [7:0] exp);
        inta = 1'b1;
        #1;
        cas_seen = m_cas_act; cas_id_seen = m_cas_id;
        @(negedge clk);
        inta = 1'b0;
        chk(tag, int'(vec_valid), 1);
        chk(tag, int'(vec_bus), int'(exp));
    endtask

    // ---------------- directed sequence
    initial begin
        cyc(5);
        rst_n = 1'b1;
        cyc(1);
        chk("R1 reset int", int'(m_int), 0);
        chk("R1 reset vec_en", int'(vec_valid), 0);
        pulse_m(5); cyc(1);
        chk("R1 unconfigured int", int'(m_int), 0);

        wr_bus(8'h20, 8'h11); wr_bus(8'h21, 8'h40); wr_bus(8'h21, 8'h04); wr_bus(8'h21, 8'h11);
        wr_bus(8'hA0, 8'h11); wr_bus(8'hA1, 8'h70); wr_bus(8'hA1, 8'h02); wr_bus(8'hA1, 8'h00);
        cyc(2);
        chk("R1 old request flushed", int'(m_int), 0);

        pulse_m(5);
        chk("R3 int raised", int'(m_int), 1);
        ack_expect("R3 vector IR5", 8'h45);
        chk("R3 no cascade on IR5", int'(cas_seen), 0);
        cyc(1);
        chk("R3 vec_en one cycle", int'(vec_valid), 0);
        chk("R7 cleared after ack", int'(m_int), 0);

        m_irq[5] = 1'b1; cyc(3);
        ack_expect("R10 edge held", 8'h45);
        cyc(3);
        chk("R10 held line gives one request", int'(m_int), 0);
        m_irq[5] = 1'b0;

        m_irq[3] = 1'b1; m_irq[6] = 1'b1; cyc(1); m_irq[3] = 1'b0; m_irq[6] = 1'b0; cyc(2);
        ack_expect("R4 IR3 beats IR6", 8'h43);
        cyc(1);
        chk("R7 lower presented without EOI", int'(m_int), 1);
        ack_expect("R7 then IR6", 8'h46);
        cyc(2);
        ack_expect("R11 spurious", 8'h47);
        cyc(2);
        chk("R11 nothing in service", int'(m_int), 0);

        wr_bus(8'h21, 8'h08);
        pulse_m(3); cyc(1);
        chk("R5 masked silent", int'(m_int), 0);
        wr_bus(8'h21, 8'h00); cyc(1);
        chk("R5 remembered edge", int'(m_int), 1);
        ack_expect("R5 vector", 8'h43);

        pulse_s(4);
        chk("R8 slave request via IR2", int'(m_int), 1);
        ack_expect("R8 slave vector", 8'h74);
        chk("R8 cascade active", int'(cas_seen), 1);
        chk("R8 cascade id", int'(cas_id_seen), 2);
        chk("R8 master silent", int'(m_ven), 0);
        wr_bus(8'hA0, 8'h20); cyc(2);

        wr_bus(8'h20, 8'h11); wr_bus(8'h21, 8'h40); wr_bus(8'h21, 8'h04); wr_bus(8'h21, 8'h10);
        pulse_m(5);
        ack_expect("R6 IR5", 8'h45);
        pulse_m(6); cyc(1);
        chk("R6 lower held", int'(m_int), 0);
        pulse_m(1);
        chk("R6 higher nests", int'(m_int), 1);
        ack_expect("R6 IR1", 8'h41);
        wr_bus(8'h20, 8'h20); cyc(1);
        chk("R6 EOI retires only IR1", int'(m_int), 0);
        wr_bus(8'h20, 8'h20); cyc(1);
        chk("R6 second EOI frees IR6", int'(m_int), 1);
        ack_expect("R6 IR6", 8'h46);
        wr_bus(8'h20, 8'h20); cyc(2);

        pulse_s(4);
        ack_expect("R9 first slave", 8'h74);
        cyc(2);
        pulse_s(1);
        chk("R9 nested slave request", int'(m_int), 1);
        ack_expect("R9 nested slave vector", 8'h71);
        wr_bus(8'hA0, 8'h20); wr_bus(8'hA0, 8'h20); wr_bus(8'h20, 8'h20); cyc(2);

        wr_bus(8'h20, 8'h1A); wr_bus(8'h21, 8'h80); wr_bus(8'h21, 8'hF7);
        m_irq[4] = 1'b1; cyc(3);
        chk("R2 third byte is mask", int'(m_int), 0);
        m_irq[4] = 1'b0;
        m_irq[3] = 1'b1; cyc(3);
        chk("R10 level raises", int'(m_int), 1);
        ack_expect("R2 single base 0x80", 8'h83);
        cyc(2);
        chk("R10 in service blocks", int'(m_int), 0);
        wr_bus(8'h20, 8'h20); cyc(2);
        chk("R10 level re-asserts", int'(m_int), 1);
        m_irq[3] = 1'b0; cyc(2);
        chk("R10 level drops", int'(m_int), 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1;
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule